// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Flow Gating

This block turns characters into asynchronous serial frames on one output line. Characters arrive over a valid/ready stream into a single holding register. When the shift stage is idle and the clear-to-send input is asserted (driven low), the held character moves into the shift stage and a frame goes out. The frame uses a shared 8-bit line-control word that also sets the matching receiver, so its bit positions are fixed. Bit timing comes from an external oversampling tick, and each serial bit spans 16 ticks.

Back-pressure works as follows. `in_ready` is high exactly when the holding register is empty. A character is taken on any rising clock edge where `in_valid` and `in_ready` are both high. A producer that holds `in_valid` with `in_ready` low simply waits, and its data is not taken. The frame settings are captured when a frame starts. The break bit acts on the line at once.

Top module: `serial_char_sender`

## Requirements
- R1: After reset the line is high, `in_ready`/`hold_empty` are 1 and `tx_empty` is 1.
- R2: A character is taken only on a clock edge with `in_valid` and `in_ready` both high. While the holding register is full, `in_ready` is 0.
- R3: A frame is a low start bit, then the data bits LSB first, then stop bits at high level. `line_ctrl[1:0]` sets the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that count are ignored.
- R4: `line_ctrl[2]`=0 sends one stop bit and `line_ctrl[2]`=1 sends two.
- R5: `line_ctrl[3]`=1 adds a parity bit after the data. With `line_ctrl[5]`=0, `line_ctrl[4]`=1 gives even parity and 0 gives odd. With `line_ctrl[5]`=1, the parity bit is the inverse of `line_ctrl[4]`, so 0 sends a constant 1 and 1 sends a constant 0.
- R6: Every frame bit lasts exactly 16 `baud_tick` pulses. An 8-bit, no-parity, one-stop frame therefore leaves `tx_empty` low for 160 ticks after the load.
- R7: When the shift stage is idle, a character is in the holding register and `cts_n` is 0, the character moves into the shift stage on the next edge. `in_ready` is 1 again from that edge.
- R8: While `cts_n` is 1 no new frame starts and the character stays held. Deasserting `cts_n` during a frame does not cut that frame short.
- R9: While `line_ctrl[6]` is 1 the line is driven low, even when idle. The shift stage keeps its normal timing underneath.
- R10: `tx_empty` is 1 only when the holding register is empty and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick, one-cycle pulse, 16 per bit |
| line_ctrl | input | 8 | Line-control word: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Holding register can take a character |
| cts_n | input | 1 | Clear to send, active low |
| serial_out | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register empty status |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
The hardest states to reach from the ports need two characters in flight at once, with the flow-control input changing at a chosen moment. The bench offers a second character right after the first has moved into the shift stage. It then checks that `in_ready` drops and that the second frame starts on the edge where the first one ends. It deasserts `cts_n` partway through a frame by running a tick counter alongside the frame capture. It also holds break through a full frame and counts ticks until `tx_empty` rises, which shows that the hidden shift stage kept its timing while the line stayed low.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA_BITS = 8;
  localparam int FRAME_BITS    = 1 + MAX_DATA_BITS + 1 + 2;
  localparam int LEFT_W        = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic       spare;
    logic       brk;
    logic       par_stick;
    logic       par_even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } line_cfg_t;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic [DATA_W-1:0] held_data,
  output logic              full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      held_data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full      <= 1'b1;
      held_data <= in_data;
    end
  end

  assign in_ready = !full;

  assert_full_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(in_valid));
  assert_data_kept_while_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(full)) |-> $stable(held_data));
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import uart_tx_pkg::*;
(
  input  logic [MAX_DATA_BITS-1:0] data,
  input  line_cfg_t                cfg,
  output logic [FRAME_BITS-1:0]    frame,
  output logic [LEFT_W-1:0]        nbits
);
  int   dlen;
  int   total;
  logic par_bit;
  logic data_xor;

  always_comb begin
    dlen     = 5 + int'(cfg.wlen);
    data_xor = 1'b0;
    for (int i = 0; i < MAX_DATA_BITS; i++) begin
      if (i < dlen) data_xor = data_xor ^ data[i];
    end
    if (cfg.par_stick) par_bit = !cfg.par_even;
    else if (cfg.par_even) par_bit = data_xor;
    else par_bit = !data_xor;

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA_BITS; i++) begin
      if (i < dlen) frame[1 + i] = data[i];
    end
    if (cfg.par_en) frame[1 + dlen] = par_bit;

    total = 1 + dlen + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1);
    nbits = LEFT_W'(total);
  end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic bit_done
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_done = run && !restart && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (tick) cnt <= bit_done ? '0 : cnt + 1'b1;
  end

  assert_count_holds_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && !$past(tick) && !$past(restart)) |-> $stable(cnt));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hold_full,
  input  logic                  cts_n,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic [LEFT_W-1:0]     nbits_in,
  input  logic                  bit_done,
  output logic                  load,
  output logic                  busy,
  output logic                  line_bit
);
  logic [FRAME_BITS-1:0] sreg;
  logic [LEFT_W-1:0]     left;

  assign load     = !busy && hold_full && !cts_n;
  assign line_bit = sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sreg <= frame_in;
      left <= nbits_in;
      busy <= 1'b1;
    end else if (busy && bit_done) begin
      sreg <= {1'b1, sreg[FRAME_BITS-1:1]};
      left <= left - 1'b1;
      if (left == LEFT_W'(1)) busy <= 1'b0;
    end
  end

  assert_no_start_without_cts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_n) |=> !busy);
  assert_frame_ends_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sreg[0]));
  assert_bits_stable_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_done && !load) |=> $stable(sreg));
endmodule

// File: rtl/serial_char_sender.sv
module serial_char_sender
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] line_ctrl,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       cts_n,
  output logic       serial_out,
  output logic       hold_empty,
  output logic       tx_empty
);
  line_cfg_t                cfg;
  logic                     full;
  logic                     load;
  logic                     busy;
  logic                     line_bit;
  logic                     bit_done;
  logic [MAX_DATA_BITS-1:0] held;
  logic [FRAME_BITS-1:0]    frame;
  logic [LEFT_W-1:0]        nbits;

  assign cfg = line_cfg_t'(line_ctrl);

  tx_hold_buf #(.DATA_W(MAX_DATA_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(load), .held_data(held), .full(full)
  );

  tx_frame_build u_build (
    .data(held), .cfg(cfg), .frame(frame), .nbits(nbits)
  );

  tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load),
    .tick(baud_tick), .bit_done(bit_done)
  );

  tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .hold_full(full), .cts_n(cts_n),
    .frame_in(frame), .nbits_in(nbits), .bit_done(bit_done),
    .load(load), .busy(busy), .line_bit(line_bit)
  );

  assign serial_out = cfg.brk ? 1'b0 : (busy ? line_bit : 1'b1);
  assign hold_empty = !full;
  assign tx_empty   = !full && !busy;

  assert_load_frees_holding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold_empty);
  assert_empty_line_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (serial_out || line_ctrl[6]));
  assert_ready_tracks_holding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !load) |=> !in_ready);
endmodule

// File: tb/serial_char_sender_test.sv
module serial_char_sender_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] line_ctrl = 8'h03;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       cts_n = 1'b0;
  logic       serial_out;
  logic       hold_empty;
  logic       tx_empty;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int tdiv = 0;

  serial_char_sender uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctrl(line_ctrl),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .cts_n(cts_n),
    .serial_out(serial_out), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always #10 clk = !clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {line_ctrl, data}
  localparam logic [15:0] VEC [0:7] = '{
    16'h03A5, 16'h00F3, 16'h1B37, 16'h0A55,
    16'h2D2A, 16'h3C1F, 16'h0780, 16'h1A7F
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_frame(input logic [7:0] c, input logic [7:0] d,
                                   output logic [11:0] f);
    int n;
    int dl;
    logic x;
    logic p;
    dl = 5 + int'(c[1:0]);
    f = '1;
    f[0] = 1'b0;
    x = 1'b0;
    for (int i = 0; i < dl; i++) begin
      f[1 + i] = d[i];
      x = x ^ d[i];
    end
    n = 1 + dl;
    if (c[3]) begin
      p = c[5] ? !c[4] : (c[4] ? x : !x);
      f[n] = p;
      n = n + 1;
    end
    n = n + (c[2] ? 2 : 1);
    return n;
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic capture(input int n, input bit started, output logic [11:0] bits);
    bits = '1;
    if (!started) begin
      @(negedge clk);
      while (serial_out) @(negedge clk);
    end
    repeat (8) wait_tick();
    @(negedge clk);
    bits[0] = serial_out;
    for (int i = 1; i < n; i++) begin
      repeat (16) wait_tick();
      @(negedge clk);
      bits[i] = serial_out;
    end
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
  endtask

  logic [11:0] got;
  logic [11:0] exp;
  int nb;
  int cnt;
  bit all_low;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(serial_out == 1'b1, "R1 idle line", serial_out, 1);
    check(in_ready == 1'b1 && hold_empty == 1'b1, "R1 holding empty", in_ready, 1);
    check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 table of frame formats
    for (int v = 0; v < 8; v++) begin
      line_ctrl = VEC[v][15:8];
      nb = exp_frame(VEC[v][15:8], VEC[v][7:0], exp);
      send(VEC[v][7:0]);
      capture(nb, 1'b0, got);
      check(got == exp, "R3 R4 R5 frame bits", int'(got), int'(exp));
      wait_empty();
      check(serial_out == 1'b1 && tx_empty == 1'b1, "R10 idle after frame", serial_out, 1);
    end

    // R6 R10 frame duration in ticks, 8N1
    line_ctrl = 8'h03;
    send(8'h5A);
    @(posedge clk);
    cnt = 0;
    do begin
      wait_tick();
      cnt++;
      @(negedge clk);
    end while (!tx_empty);
    check(cnt == 160, "R6 ticks until tx_empty", cnt, 160);

    // R7 R2 holding register frees at load, second character back-pressured
    send(8'hC3);
    @(negedge clk);
    check(in_ready == 1'b1, "R7 holding empty after load", in_ready, 1);
    check(tx_empty == 1'b0 && serial_out == 1'b0, "R10 busy not empty", tx_empty, 0);
    send(8'h3C);
    check(in_ready == 1'b0 && hold_empty == 1'b0, "R2 ready low while full", in_ready, 0);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    nb = exp_frame(8'h03, 8'h3C, exp);
    capture(nb, 1'b1, got);
    check(got == exp, "R7 back-to-back second frame", int'(got), int'(exp));
    wait_empty();

    // R8 clear-to-send held off
    cts_n = 1'b1;
    send(8'h81);
    repeat (40) wait_tick();
    @(negedge clk);
    check(serial_out == 1'b1, "R8 no start without cts", serial_out, 1);
    check(in_ready == 1'b0 && tx_empty == 1'b0, "R8 character held", in_ready, 0);
    cts_n = 1'b0;
    nb = exp_frame(8'h03, 8'h81, exp);
    capture(nb, 1'b0, got);
    check(got == exp, "R8 frame after cts", int'(got), int'(exp));
    wait_empty();

    // R8 cts dropped mid frame
    send(8'h96);
    fork
      capture(nb, 1'b0, got);
      begin
        repeat (40) wait_tick();
        cts_n = 1'b1;
      end
    join
    nb = exp_frame(8'h03, 8'h96, exp);
    check(got == exp, "R8 frame completes after cts drop", int'(got), int'(exp));
    wait_empty();
    check(tx_empty == 1'b1, "R8 finished", tx_empty, 1);
    cts_n = 1'b0;

    // R9 break while idle
    line_ctrl = 8'h43;
    @(negedge clk);
    check(serial_out == 1'b0, "R9 break idle low", serial_out, 0);
    line_ctrl = 8'h03;
    @(negedge clk);
    check(serial_out == 1'b1, "R9 break released", serial_out, 1);

    // R9 break over a whole frame keeps shifter timing
    line_ctrl = 8'h43;
    send(8'hFF);
    @(posedge clk);
    cnt = 0;
    all_low = 1'b1;
    do begin
      wait_tick();
      cnt++;
      @(negedge clk);
      if (serial_out) all_low = 1'b0;
    end while (!tx_empty);
    check(all_low, "R9 line low during break", int'(all_low), 1);
    check(cnt == 160, "R9 shifter timing under break", cnt, 160);
    line_ctrl = 8'h03;
    @(negedge clk);
    check(serial_out == 1'b1, "R9 line high after break", serial_out, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule